// File: doc/BRIEF.md
# Serial-link codec control-register access engine

This block is the codec-side command handler for the control registers of a serial audio link. Each time the link receiver has decoded slots 0, 1 and 2 of an incoming frame, it pulses `rx_frame_i` and presents those three slots for one cycle. The engine then works out whether the frame carries a register read or a register write for this codec. It applies writes to a 64-word by 16-bit register file, and it prepares the reply to a read for the outbound frame that follows.

The reply consists of a return-slot-1 word, a return-slot-2 word and their valid flags. It is updated once per received frame and then held, so that the link transmitter can pick it up at any time during the next outbound frame. A frame that does not carry an accepted read clears the reply. The codec identity comes from two ID pins. Identity 0 is the primary codec, which uses the per-slot valid tags. Identities 1 to 3 are secondary codecs; for these, a matching nonzero address field in the tag marks the request as valid.

Top module: `ac_reg_engine`

## Requirements
- R1: After reset both reply valid flags are 0 and both reply words are 0. The register defaults are: word 0 (index 0x00) reads 0x0150, words 1 to 12 (indices 0x02 to 0x18) read 0x8000, and all other words read 0x0000.
- R2: An accepted write stores slot 2 bits 19:4 into the word selected by index bits 6:1 (slot 1 bits 18:13). Every later accepted read of that index returns the stored value.
- R3: An accepted read (slot 1 bit 19 = 1) sets both valid flags at the first clock edge after the frame strobe. Return slot 1 then holds the index in bits 18:12 with all other bits 0. Return slot 2 holds the register in bits 19:4 with bits 3:0 equal to 0.
- R4: A frame carrying a write (slot 1 bit 19 = 0) leaves both valid flags at 0 and both reply words at 0 after its strobe.
- R5: A frame whose frame-valid tag (tag bit 15) is 0 changes no register and produces no valid reply.
- R6: A frame whose address field (tag bits 1:0) differs from `codec_id_i` changes no register and produces no valid reply.
- R7: A frame with index bit 0 set (slot 1 bit 12) changes no register and produces no valid reply.
- R8: With `codec_id_i` = 0, a read needs the slot-1 valid tag (tag bit 14), and a write needs both that tag and the slot-2 valid tag (tag bit 13). A request without the required tags is ignored.
- R9: With `codec_id_i` nonzero and a matching address field, reads and writes are accepted whatever the values of tag bits 14 and 13.
- R10: An accepted write to index 0x00 restores every register to its R1 default. The written data is discarded.
- R11: The reply outputs change only at the clock edge that samples `rx_frame_i` high; between strobes they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_frame_i | input | 1 | One-cycle strobe: slots 0 to 2 of a received frame are present |
| rx_tag_i | input | 16 | Received slot 0 (tag) |
| rx_slot1_i | input | 20 | Received slot 1 (command: read flag, index) |
| rx_slot2_i | input | 20 | Received slot 2 (write data) |
| codec_id_i | input | 2 | This codec's identity, 0 = primary |
| tx_slot1_o | output | 20 | Reply word for return slot 1 (echoed index) |
| tx_slot2_o | output | 20 | Reply word for return slot 2 (register data) |
| tx_slot1_valid_o | output | 1 | Return slot 1 carries a valid reply |
| tx_slot2_valid_o | output | 1 | Return slot 2 carries a valid reply |

## Verification
Every reply (R3, R4 and the rejections R5 to R9) is due at the first rising edge after the strobe. The bench drives each frame just after a falling edge and compares all four reply outputs at the next falling edge. A register update from a write shows up only through a read in a later frame, so each write is followed by a read frame whose reply is compared one edge later. The idle cycles between frames are compared against the held reply to cover R11.

// File: rtl/ac_reg_pkg.sv
package ac_reg_pkg;
  localparam int TAG_W   = 16;
  localparam int SLOT_W  = 20;
  localparam int IDX_W   = 7;
  localparam int DATA_W  = 16;
  localparam int WORD_AW = IDX_W - 1;
  localparam int NUM_WORDS = 1 << WORD_AW;

  // tag bit positions
  localparam int TAG_FRAME_VALID = 15;
  localparam int TAG_CMD_VALID   = 14;
  localparam int TAG_DATA_VALID  = 13;

  typedef struct packed {
    logic               rd;
    logic               wr;
    logic               clr;
    logic [IDX_W-1:0]   index;
    logic [DATA_W-1:0]  wdata;
  } req_t;

  function automatic logic [DATA_W-1:0] dflt_word(int w);
    if (w == 0)                 return 16'h0150;
    else if (w >= 1 && w <= 12) return 16'h8000;
    else                        return '0;
  endfunction
endpackage

// File: rtl/ac_req_decode.sv
module ac_req_decode
  import ac_reg_pkg::*;
(
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [SLOT_W-1:0] slot1_i,
  input  logic [SLOT_W-1:0] slot2_i,
  input  logic [1:0]        codec_id_i,
  output req_t              req_o
);
  logic field_hit, aligned, is_rd, primary, cmd_ok, data_ok, base;
  logic [IDX_W-1:0] index;
  logic unused_bits;

  assign index     = slot1_i[SLOT_W-2 -: IDX_W];
  assign field_hit = (tag_i[1:0] == codec_id_i);
  assign aligned   = ~index[0];
  assign is_rd     = slot1_i[SLOT_W-1];
  assign primary   = (codec_id_i == 2'b00);
  // secondary codecs: matching nonzero field alone marks the slots valid
  assign cmd_ok    = primary ? tag_i[TAG_CMD_VALID]  : 1'b1;
  assign data_ok   = primary ? tag_i[TAG_DATA_VALID] : 1'b1;
  assign base      = tag_i[TAG_FRAME_VALID] & field_hit & aligned & cmd_ok;

  always_comb begin
    req_o.rd    = base & is_rd;
    req_o.wr    = base & ~is_rd & data_ok;
    req_o.clr   = base & ~is_rd & data_ok & (index == '0);
    req_o.index = index;
    req_o.wdata = slot2_i[SLOT_W-1 -: DATA_W];
  end

  assign unused_bits = ^{tag_i[12:2], slot1_i[SLOT_W-IDX_W-2:0], slot2_i[SLOT_W-DATA_W-1:0]};
endmodule

// File: rtl/ac_reg_file.sv
module ac_reg_file
  import ac_reg_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = WORD_AW,
  parameter int WORDS = NUM_WORDS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_word_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          clr_i,
  input  logic [AW-1:0] rd_word_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    if (w == 0) begin : g_ro
      // index 0 is the reset trigger; it reads a fixed value
      assign words[w] = DW'(dflt_word(w));
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                   q <= DW'(dflt_word(w));
        else if (clr_i)                                q <= DW'(dflt_word(w));
        else if (wr_en_i && wr_word_i == AW'(w))       q <= wr_data_i;
      end
      assign words[w] = q;
    end
  end

  assign rd_data_o = words[rd_word_i];

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i && wr_word_i != '0) |=> words[$past(wr_word_i)] == $past(wr_data_i));

  assert_clear_restores_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (words[1] == DW'(dflt_word(1))) && (words[WORDS-1] == DW'(dflt_word(WORDS-1))));
endmodule

// File: rtl/ac_reply_gen.sv
module ac_reply_gen
  import ac_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [SLOT_W-1:0] slot1_o,
  output logic [SLOT_W-1:0] slot2_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      slot1_o <= '0;
      slot2_o <= '0;
    end else if (strobe_i) begin
      valid_o <= rd_i;
      slot1_o <= rd_i ? {1'b0, index_i, {(SLOT_W-IDX_W-1){1'b0}}} : '0;
      slot2_o <= rd_i ? {rd_data_i, {(SLOT_W-DATA_W){1'b0}}} : '0;
    end
  end

  assert_reply_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(slot1_o) && $stable(slot2_o) && $stable(valid_o));

  assert_reply_follows_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && rd_i) |=> valid_o && slot2_o[3:0] == '0);
endmodule

// File: rtl/ac_reg_engine.sv
module ac_reg_engine
  import ac_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_frame_i,
  input  logic [TAG_W-1:0]  rx_tag_i,
  input  logic [SLOT_W-1:0] rx_slot1_i,
  input  logic [SLOT_W-1:0] rx_slot2_i,
  input  logic [1:0]        codec_id_i,
  output logic [SLOT_W-1:0] tx_slot1_o,
  output logic [SLOT_W-1:0] tx_slot2_o,
  output logic              tx_slot1_valid_o,
  output logic              tx_slot2_valid_o
);
  req_t req;
  logic [DATA_W-1:0] rd_data;
  logic reply_valid;

  ac_req_decode i_decode (
    .tag_i      (rx_tag_i),
    .slot1_i    (rx_slot1_i),
    .slot2_i    (rx_slot2_i),
    .codec_id_i (codec_id_i),
    .req_o      (req)
  );

  ac_reg_file i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (rx_frame_i & req.wr),
    .wr_word_i (req.index[IDX_W-1:1]),
    .wr_data_i (req.wdata),
    .clr_i     (rx_frame_i & req.clr),
    .rd_word_i (req.index[IDX_W-1:1]),
    .rd_data_o (rd_data)
  );

  ac_reply_gen i_reply (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (rx_frame_i),
    .rd_i      (req.rd),
    .index_i   (req.index),
    .rd_data_i (rd_data),
    .slot1_o   (tx_slot1_o),
    .slot2_o   (tx_slot2_o),
    .valid_o   (reply_valid)
  );

  assign tx_slot1_valid_o = reply_valid;
  assign tx_slot2_valid_o = reply_valid;

  assert_write_no_reply_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_frame_i && !rx_slot1_i[SLOT_W-1]) |=> !tx_slot1_valid_o && !tx_slot2_valid_o);

  assert_frame_invalid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_frame_i && !rx_tag_i[TAG_FRAME_VALID]) |=> !tx_slot1_valid_o);

  assert_id_mismatch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_frame_i && rx_tag_i[1:0] != codec_id_i) |=> !tx_slot1_valid_o);

  assert_odd_index_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_frame_i && rx_slot1_i[SLOT_W-IDX_W-1]) |=> !tx_slot1_valid_o);

  assert_primary_tags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_frame_i && codec_id_i == 2'b00 && !rx_tag_i[TAG_CMD_VALID]) |=> !tx_slot1_valid_o);
endmodule

// File: tb/test_ac_reg_engine.sv
module test_ac_reg_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_frame = 1'b0;
  logic [15:0] rx_tag = '0;
  logic [19:0] rx_s1 = '0, rx_s2 = '0;
  logic [1:0]  cid = 2'b00;
  logic [19:0] tx_s1, tx_s2;
  logic        tx_v1, tx_v2;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] model [64];
  logic [19:0] e_s1, e_s2;
  logic        e_v;

  always #5 clk = ~clk;

  ac_reg_engine i_ac_reg_engine (
    .clk_i(clk), .rst_ni(rst_n), .rx_frame_i(rx_frame), .rx_tag_i(rx_tag),
    .rx_slot1_i(rx_s1), .rx_slot2_i(rx_s2), .codec_id_i(cid),
    .tx_slot1_o(tx_s1), .tx_slot2_o(tx_s2),
    .tx_slot1_valid_o(tx_v1), .tx_slot2_valid_o(tx_v2)
  );

  function automatic logic [15:0] def_val(int w);
    if (w == 0) return 16'h0150;
    if (w <= 12) return 16'h8000;
    return 16'h0000;
  endfunction

  task automatic model_reset();
    for (int w = 0; w < 64; w++) model[w] = def_val(w);
  endtask

  // wait for falling edge, compare every output against the model
  task automatic tick(string req);
    @(negedge clk);
    checks++;
    if (tx_v1 !== e_v || tx_v2 !== e_v || tx_s1 !== e_s1 || tx_s2 !== e_s2) begin
      errors++;
      $display("FAIL %s: got v=%b/%b s1=%h s2=%h, expected v=%b s1=%h s2=%h",
               req, tx_v1, tx_v2, tx_s1, tx_s2, e_v, e_s1, e_s2);
    end
  endtask

  task automatic frame(input logic [15:0] tag, input logic rw, input logic [6:0] idx,
                       input logic [15:0] data, input string req);
    bit acc;
    bit primary;
    primary = (cid == 2'b00);
    rx_tag = tag;
    rx_s1  = {rw, idx, 12'h000};
    rx_s2  = {data, 4'h0};
    rx_frame = 1'b1;
    acc = tag[15] && (tag[1:0] == cid) && !idx[0] &&
          (primary ? (tag[14] && (rw || tag[13])) : 1'b1);
    if (acc && rw) begin
      e_v = 1'b1; e_s1 = {1'b0, idx, 12'h000}; e_s2 = {model[idx >> 1], 4'h0};
    end else begin
      e_v = 1'b0; e_s1 = '0; e_s2 = '0;
    end
    if (acc && !rw) begin
      if (idx == 7'h00) model_reset();
      else model[idx >> 1] = data;
    end
    tick(req);
    rx_frame = 1'b0;
    rx_tag = $urandom;
    rx_s1 = $urandom;
    rx_s2 = $urandom;
    tick({req, " R11 hold"});
    tick({req, " R11 hold"});
  endtask

  localparam logic [15:0] T_RD = 16'hC000;
  localparam logic [15:0] T_WR = 16'hE000;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    e_v = 0; e_s1 = '0; e_s2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick("R1 reset outputs");
    frame(T_RD, 1, 7'h02, 16'h0, "R1 default word1");
    frame(T_RD, 1, 7'h00, 16'h0, "R1 default word0");
    frame(T_RD, 1, 7'h18, 16'h0, "R1 default word12");
    frame(T_RD, 1, 7'h40, 16'h0, "R1 default word32");
    frame(T_WR, 0, 7'h02, 16'h1234, "R4 write no reply");
    frame(T_RD, 1, 7'h02, 16'h0, "R2 read back");
    frame(T_WR, 0, 7'h7E, 16'hABCD, "R4 write top");
    frame(T_RD, 1, 7'h7E, 16'hFFFF, "R3 read reply format");
    frame(16'h6000, 1, 7'h02, 16'h0, "R5 read frame invalid");
    frame(16'h6000, 0, 7'h02, 16'h5555, "R5 write frame invalid");
    frame(T_RD, 1, 7'h02, 16'h0, "R5 unchanged");
    frame(T_WR | 16'h0001, 0, 7'h04, 16'h7777, "R6 write wrong field");
    frame(T_RD | 16'h0003, 1, 7'h04, 16'h0, "R6 read wrong field");
    frame(T_RD, 1, 7'h04, 16'h0, "R6 unchanged");
    frame(T_WR, 0, 7'h03, 16'h9999, "R7 odd write");
    frame(T_RD, 1, 7'h05, 16'h0, "R7 odd read");
    frame(T_RD, 1, 7'h02, 16'h0, "R7 unchanged");
    frame(16'hC000, 0, 7'h06, 16'h4242, "R8 write missing data tag");
    frame(16'h8000, 1, 7'h06, 16'h0, "R8 read missing cmd tag");
    frame(16'hA000, 0, 7'h06, 16'h4242, "R8 write missing cmd tag");
    frame(T_RD, 1, 7'h06, 16'h0, "R8 unchanged");
    cid = 2'b10;
    frame(16'h8002, 0, 7'h08, 16'hBEEF, "R9 secondary write");
    frame(16'h8002, 1, 7'h08, 16'h0, "R9 secondary read");
    frame(T_RD, 1, 7'h08, 16'h0, "R6 primary field on secondary");
    frame(16'hE003, 1, 7'h08, 16'h0, "R6 other secondary");
    cid = 2'b00;
    frame(T_WR, 0, 7'h00, 16'hFFFF, "R10 reset write");
    frame(T_RD, 1, 7'h02, 16'h0, "R10 word1 default");
    frame(T_RD, 1, 7'h7E, 16'h0, "R10 top default");
    frame(T_RD, 1, 7'h08, 16'h0, "R10 word4 default");
    frame(T_RD, 1, 7'h00, 16'h0, "R10 word0 fixed");
    for (int i = 0; i < 200; i++) begin
      logic [15:0] tg;
      logic [6:0]  ix;
      tg = {($urandom % 8) != 0, 1'b1, ($urandom % 4) != 0, 11'h0,
            (($urandom % 8) == 0) ? 2'b01 : 2'b00};
      ix = (($urandom % 10) == 0) ? 7'($urandom) : {6'($urandom % 8), 1'b0};
      if (ix == 7'h00 && ($urandom % 4) != 0) ix = 7'h02;
      frame(tg, 1'($urandom), ix, 16'($urandom), "R2 R3 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule